// File: doc/BRIEF.md
# Selectable-Order Seven-to-One Pixel Lane Packer

This block sits on the transmit side of a flat-panel link. Every pixel period it takes one 24-bit RGB pixel and its data-enable flag, spreads the 28 slot positions over four data lanes of seven bits each, and shifts them out one slot at a time next to a fifth lane that carries the link clock shape. Two bit orderings are in common industrial use. They differ only in whether the two most significant or the two least significant bits of each colour travel on the fourth lane. A single select input picks between them.

The block runs on one fast clock with a slot strobe (`slot_en`) that fires seven times per pixel period. The first strobe of each group of seven captures the pixel and the select in one step. The strobes that follow shift the captured word out, so a word is never built from two formats. `frame_o` marks the slot that opens each pixel word. One instance serves one pixel channel. A dual-channel link uses two instances, one for the even pixels and one for the odd pixels.

Top module: `lvds_pixel_packer`

## Requirements
- R1: While `rst` is high, and after it falls until the first `slot_en`, all of `lane_o`, `clk_lane_o` and `frame_o` are 0. The first `slot_en` after reset opens a new pixel word.
- R2: With `fmt_sel` = 0, lane 0 carries R[0..5] in slots 0..5 and G[0] in slot 6. Lane 1 carries G[1..5] in slots 0..4, then B[0] in slot 5 and B[1] in slot 6. Lane 2 carries B[2..5] in slots 0..3.
- R3: With `fmt_sel` = 0, lane 3 carries R[6], R[7], G[6], G[7], B[6], B[7] in slots 0..5.
- R4: With `fmt_sel` = 1, lanes 0..2 use the same slot layout as R2, with colour bit k+2 in place of colour bit k. For example, lane 0 slot 0 is R[2] and lane 0 slot 6 is G[2].
- R5: With `fmt_sel` = 1, lane 3 carries R[0], R[1], G[0], G[1], B[0], B[1] in slots 0..5.
- R6: DE is in lane 2 slot 6 in both formats. Lane 2 slots 4 and 5 and lane 3 slot 6 are reserved and are driven to 0.
- R7: The clock lane sends 1,1,0,0,0,1,1 in slots 0..6 of every pixel word. `frame_o` is 1 exactly while slot 0 is on the outputs.
- R8: Slot 0 leaves on the edge of the first `slot_en` of a group, and each later `slot_en` advances by one slot. All outputs hold while `slot_en` is low. Pixel inputs that change after the first strobe of a word have no effect on that word.
- R9: A change of `fmt_sel` in the middle of a word leaves the rest of that word in the format that was captured. The new format applies from the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_en | input | 1 | Slot strobe, seven per pixel period |
| fmt_sel | input | 1 | Bit-order select: 0 = top colour bits on lane 3, 1 = bottom colour bits on lane 3 |
| pix_r | input | 8 | Red component |
| pix_g | input | 8 | Green component |
| pix_b | input | 8 | Blue component |
| pix_de | input | 1 | Data-enable flag for the pixel |
| lane_o | output | 4 | Serial bit of data lanes 3..0 |
| clk_lane_o | output | 1 | Serial bit of the clock lane |
| frame_o | output | 1 | High while slot 0 of a word is on the outputs |

## Verification
The bench drives pixels with asymmetric colour values in both formats. Each lane word is checked on its own, so two colour bits that trade places, or a format that puts the wrong pair on lane 3, shows up as a lane miscompare. Two pixels keep DE on in both formats, and this exposes a DE bit that moves or drops when the format changes. One pixel is scrambled just after its first strobe and another has its select flipped in mid-word; a design that samples late or packs per slot would then emit a mixed word. Idle cycles inserted between strobes catch a shifter that advances without `slot_en`. The slot-0 marker and the clock shape catch a counter that is off by one slot.

// File: rtl/lvds_pk_pkg.sv
package lvds_pk_pkg;

    parameter int SLOTS    = 7;
    parameter int DLANES   = 4;
    parameter int COLOR_W  = 8;
    localparam int LOW_W   = SLOTS - 1;          // colour bits spread over lanes 0..2
    localparam int HIGH_W  = COLOR_W - LOW_W;    // colour bits carried on lane 3

    typedef logic [SLOTS-1:0] slot_word_t;       // bit s is sent in slot s

    typedef enum logic {
        FMT_TOP_ON_L3 = 1'b0,
        FMT_BOT_ON_L3 = 1'b1
    } pack_fmt_e;

    typedef struct packed {
        logic [COLOR_W-1:0] r;
        logic [COLOR_W-1:0] g;
        logic [COLOR_W-1:0] b;
        logic               de;
    } pixel_t;

    typedef struct packed {
        slot_word_t l3;
        slot_word_t l2;
        slot_word_t l1;
        slot_word_t l0;
    } lane_set_t;

    localparam slot_word_t CLK_SHAPE = 7'b1100011;

    function automatic logic [LOW_W-1:0] low_group(input logic [COLOR_W-1:0] c,
                                                   input pack_fmt_e f);
        return (f == FMT_BOT_ON_L3) ? c[COLOR_W-1:HIGH_W] : c[LOW_W-1:0];
    endfunction

    function automatic logic [HIGH_W-1:0] high_group(input logic [COLOR_W-1:0] c,
                                                     input pack_fmt_e f);
        return (f == FMT_BOT_ON_L3) ? c[HIGH_W-1:0] : c[COLOR_W-1:LOW_W];
    endfunction

endpackage

// File: rtl/lvds_pk_slot_ctr.sv
module lvds_pk_slot_ctr #(
    parameter int SLOTS = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic slot_en,
    output logic first_slot
);
    localparam int CNT_W = $clog2(SLOTS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOTS - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (slot_en)
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    assign first_slot = (cnt_q == '0);

    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);                                          // R8
    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (slot_en && cnt_q == LAST) |=> first_slot);              // R8

endmodule

// File: rtl/lvds_pk_lane_ser.sv
module lvds_pk_lane_ser #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         slot_en,
    input  logic         load,
    input  logic [W-1:0] word,
    output logic         ser_o
);
    logic         bit_q;
    logic [W-2:0] rest_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q  <= 1'b0;
            rest_q <= '0;
        end else if (slot_en) begin
            if (load) begin
                bit_q  <= word[0];
                rest_q <= word[W-1:1];
            end else begin
                bit_q  <= rest_q[0];
                rest_q <= rest_q >> 1;
            end
        end
    end

    assign ser_o = bit_q;

    AST_LANE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !slot_en |=> $stable(ser_o));                            // R8

endmodule

// File: rtl/lvds_pixel_packer.sv
module lvds_pixel_packer
    import lvds_pk_pkg::*;
#(
    parameter logic RSV_LEVEL = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               slot_en,
    input  logic               fmt_sel,
    input  logic [COLOR_W-1:0] pix_r,
    input  logic [COLOR_W-1:0] pix_g,
    input  logic [COLOR_W-1:0] pix_b,
    input  logic               pix_de,
    output logic [DLANES-1:0]  lane_o,
    output logic               clk_lane_o,
    output logic               frame_o
);
    localparam int ALL_LANES = DLANES + 1;   // data lanes plus clock lane

    pixel_t     pix;
    pack_fmt_e  fmt;
    lane_set_t  packed_w;
    slot_word_t words [ALL_LANES];
    logic       first_slot;
    logic       frame_q;
    logic [ALL_LANES-1:0] ser;

    assign pix = '{r: pix_r, g: pix_g, b: pix_b, de: pix_de};
    assign fmt = pack_fmt_e'(fmt_sel);

    always_comb begin
        logic [LOW_W-1:0]  rl, gl, bl;
        logic [HIGH_W-1:0] rh, gh, bh;
        rl = low_group(pix.r, fmt);
        gl = low_group(pix.g, fmt);
        bl = low_group(pix.b, fmt);
        rh = high_group(pix.r, fmt);
        gh = high_group(pix.g, fmt);
        bh = high_group(pix.b, fmt);
        packed_w.l0 = {gl[0], rl};
        packed_w.l1 = {bl[1:0], gl[LOW_W-1:1]};
        packed_w.l2 = {pix.de, RSV_LEVEL, RSV_LEVEL, bl[LOW_W-1:2]};
        packed_w.l3 = {RSV_LEVEL, bh, gh, rh};
    end

    assign words[0] = packed_w.l0;
    assign words[1] = packed_w.l1;
    assign words[2] = packed_w.l2;
    assign words[3] = packed_w.l3;
    assign words[4] = CLK_SHAPE;

    lvds_pk_slot_ctr #(.SLOTS(SLOTS)) u_ctr (
        .clk        (clk),
        .rst        (rst),
        .slot_en    (slot_en),
        .first_slot (first_slot)
    );

    for (genvar i = 0; i < ALL_LANES; i++) begin : g_lane
        lvds_pk_lane_ser #(.W(SLOTS)) u_ser (
            .clk     (clk),
            .rst     (rst),
            .slot_en (slot_en),
            .load    (first_slot),
            .word    (words[i]),
            .ser_o   (ser[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            frame_q <= 1'b0;
        else if (slot_en)
            frame_q <= first_slot;
    end

    assign lane_o     = ser[DLANES-1:0];
    assign clk_lane_o = ser[DLANES];
    assign frame_o    = frame_q;

    AST_FRAME_CLK_HIGH: assert property (@(posedge clk) disable iff (rst)
        frame_o |-> clk_lane_o);                                 // R7
    AST_FRAME_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (slot_en && frame_o) |=> !frame_o);                      // R7
    AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (rst)
        !slot_en |=> $stable(frame_o));                          // R8
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (lane_o == '0 && !clk_lane_o && !frame_o));      // R1

endmodule

// File: tb/lvds_pixel_packer_tb.sv
module lvds_pixel_packer_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       slot_en = 1'b0;
    logic       fmt_sel = 1'b0;
    logic [7:0] pix_r = '0, pix_g = '0, pix_b = '0;
    logic       pix_de = 1'b0;
    logic [3:0] lane_o;
    logic       clk_lane_o, frame_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    lvds_pixel_packer u_dut (
        .clk(clk), .rst(rst), .slot_en(slot_en), .fmt_sel(fmt_sel),
        .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b), .pix_de(pix_de),
        .lane_o(lane_o), .clk_lane_o(clk_lane_o), .frame_o(frame_o)
    );

    // {fmt, r, g, b, de}
    localparam logic [25:0] VEC [8] = '{
        {1'b0, 8'h01, 8'h00, 8'h00, 1'b0},
        {1'b0, 8'hC0, 8'h81, 8'h42, 1'b1},
        {1'b0, 8'h5A, 8'hA5, 8'h3C, 1'b0},
        {1'b1, 8'h01, 8'h02, 8'h80, 1'b0},
        {1'b1, 8'hC3, 8'h5A, 8'h96, 1'b1},
        {1'b1, 8'hFF, 8'h00, 8'hFF, 1'b0},
        {1'b0, 8'hFF, 8'hFF, 8'hFF, 1'b1},
        {1'b1, 8'h12, 8'h34, 8'h56, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // colour bit in a lane-0..2 position i (0..5)
    function automatic logic lo(input logic [7:0] c, input int i, input logic f);
        return f ? c[i+2] : c[i];
    endfunction
    // colour bit in a lane-3 position j (0..1)
    function automatic logic hi(input logic [7:0] c, input int j, input logic f);
        return f ? c[j] : c[j+6];
    endfunction

    function automatic logic [6:0] exp_word(input int lane, input logic f,
            input logic [7:0] r, input logic [7:0] g, input logic [7:0] b, input logic de);
        logic [6:0] w;
        for (int s = 0; s < 7; s++) begin
            case (lane)
                0: w[s] = (s < 6) ? lo(r, s, f) : lo(g, 0, f);
                1: w[s] = (s < 5) ? lo(g, s + 1, f) : lo(b, s - 5, f);
                2: w[s] = (s < 4) ? lo(b, s + 2, f) : (s == 6) ? de : 1'b0;
                default: case (s)
                    0, 1: w[s] = hi(r, s, f);
                    2, 3: w[s] = hi(g, s - 2, f);
                    4, 5: w[s] = hi(b, s - 4, f);
                    default: w[s] = 1'b0;
                endcase
            endcase
        end
        return w;
    endfunction

    // Sends one pixel word; called and returning at a falling edge.
    task automatic run_pixel(input logic f, input logic [7:0] r, input logic [7:0] g,
                             input logic [7:0] b, input logic de,
                             input bit scramble, input bit flip_fmt, input bit gaps);
        logic [6:0] got [4];
        logic [6:0] got_clk, got_frm;
        logic [5:0] held;
        string rq_lo, rq_hi;
        fmt_sel = f; pix_r = r; pix_g = g; pix_b = b; pix_de = de;
        for (int s = 0; s < 7; s++) begin
            slot_en = 1'b1;
            @(negedge clk);
            slot_en = 1'b0;
            for (int l = 0; l < 4; l++) got[l][s] = lane_o[l];
            got_clk[s] = clk_lane_o;
            got_frm[s] = frame_o;
            if (s == 0 && scramble) begin
                pix_r = ~r; pix_g = ~g; pix_b = ~b; pix_de = ~de;
            end
            if (s == 0 && flip_fmt) fmt_sel = ~f;
            if (gaps) begin
                held = {frame_o, clk_lane_o, lane_o};
                @(negedge clk);
                @(negedge clk);
                chk("R8 outputs hold without slot_en", 32'(held),
                    32'({frame_o, clk_lane_o, lane_o}));
            end
        end
        rq_lo = f ? "R4" : "R2";
        rq_hi = f ? "R5" : "R3";
        chk({rq_lo, " lane0"}, 32'(got[0]), 32'(exp_word(0, f, r, g, b, de)));
        chk({rq_lo, " lane1"}, 32'(got[1]), 32'(exp_word(1, f, r, g, b, de)));
        chk({rq_lo, "/R6 lane2"}, 32'(got[2]), 32'(exp_word(2, f, r, g, b, de)));
        chk({rq_hi, "/R6 lane3"}, 32'(got[3]), 32'(exp_word(3, f, r, g, b, de)));
        chk("R7 clock lane shape", 32'(got_clk), 32'(7'b1100011));
        chk("R7 frame marker on slot 0", 32'(got_frm), 32'(7'b0000001));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        chk("R1 reset outputs", 32'({frame_o, clk_lane_o, lane_o}), 32'h0);
        rst = 1'b0;
        pix_r = 8'hFF; pix_g = 8'hFF; pix_b = 8'hFF; pix_de = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 quiet before first slot_en", 32'({frame_o, clk_lane_o, lane_o}), 32'h0);

        // table walk (first pixel after reset also covers R1 word start)
        foreach (VEC[i]) begin
            run_pixel(VEC[i][25], VEC[i][24:17], VEC[i][16:9], VEC[i][8:1], VEC[i][0],
                      1'b0, 1'b0, (i % 3) == 2);
        end

        // R8: pixel inputs change after the capture strobe
        run_pixel(1'b0, 8'h3C, 8'hC3, 8'h69, 1'b1, 1'b1, 1'b0, 1'b0);
        run_pixel(1'b1, 8'hA1, 8'h1A, 8'h5F, 1'b0, 1'b1, 1'b0, 1'b1);

        // R9: select flips mid-word; next word takes the new format
        run_pixel(1'b0, 8'h87, 8'h4B, 8'h2D, 1'b1, 1'b0, 1'b1, 1'b0);
        run_pixel(1'b1, 8'h87, 8'h4B, 8'h2D, 1'b1, 1'b0, 1'b0, 1'b0);
        run_pixel(1'b1, 8'hE1, 8'h1E, 8'h78, 1'b0, 1'b0, 1'b1, 1'b0);
        run_pixel(1'b0, 8'hE1, 8'h1E, 8'h78, 1'b0, 1'b0, 1'b0, 1'b0);

        // R1: reset in mid-word restarts at slot 0
        slot_en = 1'b1; @(negedge clk); @(negedge clk); slot_en = 1'b0;
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        chk("R1 mid-word reset clears outputs", 32'({frame_o, clk_lane_o, lane_o}), 32'h0);
        run_pixel(1'b0, 8'h81, 8'h18, 8'hC6, 1'b1, 1'b0, 1'b0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule